// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide, two-address register interface of one interrupt controller. It turns host writes into three kinds of word. An initialization word starts a short programming sequence. A control word arms a poll or chooses what address 0 reads return. A command word produces an end-of-interrupt, priority or rotation request toward the priority core. It also holds the controller's configuration: the mask register, the vector base, and the auto-EOI, nested, special-mask and rotate flags.

The priority core sits next to this block and is not part of it. The core supplies its request and in-service registers, plus the line that would win a poll. This block sends it one-cycle command strobes with a line operand. It also sends an acknowledge strobe when a poll read claims a line, so the core can clear that line's request and in-service bits. Every register and strobe updates on the clock edge that samples the access and is visible in the following cycle.

Top module: `irqc_prog_port`

## Requirements
- R1: After reset, mask, vector base, auto-EOI, nested, special-mask and rotate flags are 0, no strobe is active, poll is disarmed, address 0 reads return the request register, and address 1 writes load the mask.
- R2: A write to address 0 with bit 4 set pulses init_clear_o for one cycle. It clears mask, vector base, auto-EOI, nested, special mask, rotate flag, register select and poll. It records bit 0 as "fourth word needed", and the next address 1 write is taken as the vector base.
- R3: The first address 1 write after an initialization word sets the vector base to the data with bits 2:0 forced to 0.
- R4: The second address 1 write after an initialization word changes no output. The sequence then expects a fourth word if bit 0 of the initialization word was 1, and otherwise returns to mask loading.
- R5: The fourth word sets nested mode from bit 4 and auto-EOI from bit 1, then returns to mask loading.
- R6: Outside the initialization sequence, an address 1 write loads the whole byte into the mask register.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 arms the poll. Bit 1 allows register select to take bit 0 (1 = in-service, 0 = request). Bit 6 allows special mask to take bit 5. Fields that are not enabled keep their value.
- R8: A command word (address 0, bits 4 and 3 clear) with bits 7:5 = 0 clears the rotate-on-auto-EOI flag, and with code 4 sets it.
- R9: Command codes drive one-cycle strobes, at most one at a time: 1 drives eoi_o, 5 drives eoi_rot_o, 3 drives eoi_spec_o, 7 drives rot_spec_o and 6 drives set_prio_o. The codes that carry a line (3, 7, 6) give it on cmd_line_o from bits 2:0. Code 2 drives nothing.
- R10: With poll disarmed, the data registered after a read is the request register (address 0, select 0), the in-service register (address 0, select 1) or the mask (address 1).
- R11: With poll armed, the next read at either address returns the winning line and pulses poll_ack_o when the core reports a winner. With no winner it returns 7 and gives no acknowledge. Either way the poll disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| req_i | input | 8 | Request register from the priority core |
| isr_i | input | 8 | In-service register from the priority core |
| poll_hit_i | input | 1 | Core has a line that would win a poll |
| poll_line_i | input | 3 | That winning line |
| rdata_o | output | 8 | Registered read data |
| poll_ack_o | output | 1 | Poll read claimed poll_line_i |
| init_clear_o | output | 1 | Initialization word seen: clear core state, drop the request |
| eoi_o | output | 1 | Non-specific end of interrupt |
| eoi_rot_o | output | 1 | Non-specific end of interrupt with rotation |
| eoi_spec_o | output | 1 | Specific end of interrupt on cmd_line_o |
| rot_spec_o | output | 1 | Specific end of interrupt and rotate on cmd_line_o |
| set_prio_o | output | 1 | Make cmd_line_o the lowest priority |
| cmd_line_o | output | 3 | Line operand of the command |
| vec_base_o | output | 8 | Vector base |
| auto_eoi_o | output | 1 | Auto end of interrupt |
| nested_o | output | 1 | Special fully nested mode |
| special_mask_o | output | 1 | Special mask mode |
| rot_auto_eoi_o | output | 1 | Rotate on auto end of interrupt |
| mask_o | output | 8 | Mask register |

## Verification
The hardest cases to reach are the interactions between the initialization sequence and other traffic. Examples are a mask write that lands in the ignored third slot, a fresh initialization word that interrupts a sequence half-way, and a poll armed by a control word that sits between sequence words. Random writes draw address and full data byte freely, so all three word types mix with sequence words in every order. A bench model tracks the sequence position and every configuration field and predicts each output. Directed runs also cover both sequence lengths, every command code, and poll reads with and without a winner.

// File: rtl/irqc_port_pkg.sv
package irqc_port_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_SKIP, ST_EXTRA} seq_st_e;
  typedef enum logic [2:0] {
    OP_ROT_CLR  = 3'd0,
    OP_EOI      = 3'd1,
    OP_NOP      = 3'd2,
    OP_EOI_SPEC = 3'd3,
    OP_ROT_SET  = 3'd4,
    OP_EOI_ROT  = 3'd5,
    OP_SET_PRIO = 3'd6,
    OP_ROT_SPEC = 3'd7
  } op_e;
endpackage

// File: rtl/irqc_word_decode.sv
module irqc_word_decode
  import irqc_port_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          is_init_o,
  output logic          is_ctrl_o,
  output logic          is_cmd_o,
  output logic          is_data_o,
  output op_e           op_o,
  output logic [LW-1:0] line_o
);
  logic cmd_space;
  assign cmd_space = wr_i && !addr_i;
  assign is_init_o = cmd_space && wdata_i[4];
  assign is_ctrl_o = cmd_space && !wdata_i[4] && wdata_i[3];
  assign is_cmd_o  = cmd_space && !wdata_i[4] && !wdata_i[3];
  assign is_data_o = wr_i && addr_i;
  assign op_o      = op_e'(wdata_i[7:5]);
  assign line_o    = wdata_i[LW-1:0];
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_port_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          is_init_i,
  input  logic          is_data_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] vec_base_o,
  output logic          nested_o,
  output logic          auto_eoi_o
);
  seq_st_e st_q;
  logic    need4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      need4_q    <= 1'b0;
      mask_o     <= '0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
    end else if (is_init_i) begin
      st_q       <= ST_BASE;
      need4_q    <= wdata_i[0];
      mask_o     <= '0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
    end else if (is_data_i) begin
      unique case (st_q)
        ST_RUN:  mask_o <= wdata_i;
        ST_BASE: begin
          vec_base_o <= {wdata_i[DW-1:LW], {LW{1'b0}}};
          st_q       <= ST_SKIP;
        end
        ST_SKIP: st_q <= need4_q ? ST_EXTRA : ST_RUN;
        ST_EXTRA: begin
          nested_o   <= wdata_i[4];
          auto_eoi_o <= wdata_i[1];
          st_q       <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  a_r3_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data_i && st_q == ST_BASE) |=> (vec_base_o[LW-1:0] == '0 && st_q == ST_SKIP));
  a_r4_skip_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data_i && st_q == ST_SKIP) |=> ($stable(mask_o) && $stable(vec_base_o) &&
                                        $stable(nested_o) && $stable(auto_eoi_o)));
  a_r6_mask_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_o) |-> ($past(is_init_i) || $past(is_data_i && st_q == ST_RUN)));
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_init_i |=> (st_q == ST_BASE && mask_o == '0));
endmodule

// File: rtl/irqc_read_path.sv
module irqc_read_path #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic          clear_i,
  input  logic          arm_poll_i,
  input  logic          sel_we_i,
  input  logic          sel_val_i,
  input  logic [DW-1:0] req_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] mask_i,
  input  logic          poll_hit_i,
  input  logic [LW-1:0] poll_line_i,
  output logic [DW-1:0] rdata_o,
  output logic          poll_ack_o
);
  localparam logic [DW-1:0] NO_WINNER = DW'((1 << LW) - 1);

  logic poll_q, sel_isr_q;
  logic [DW-1:0] rd_next;

  always_comb begin
    if (poll_q)      rd_next = poll_hit_i ? DW'(poll_line_i) : NO_WINNER;
    else if (addr_i) rd_next = mask_i;
    else             rd_next = sel_isr_q ? isr_i : req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q     <= 1'b0;
      sel_isr_q  <= 1'b0;
      rdata_o    <= '0;
      poll_ack_o <= 1'b0;
    end else begin
      poll_ack_o <= rd_i && poll_q && poll_hit_i;
      if (rd_i) rdata_o <= rd_next;
      if (clear_i) begin
        poll_q    <= 1'b0;
        sel_isr_q <= 1'b0;
      end else begin
        if (arm_poll_i)  poll_q <= 1'b1;
        else if (rd_i)   poll_q <= 1'b0;
        if (sel_we_i)    sel_isr_q <= sel_val_i;
      end
    end
  end

  a_r11_ack_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_ack_o |-> $past(rd_i && poll_q && poll_hit_i));
  a_r11_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !arm_poll_i) |=> !poll_q);
endmodule

// File: rtl/irqc_prog_port.sv
module irqc_prog_port
  import irqc_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic                     addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [DW-1:0]            req_i,
  input  logic [DW-1:0]            isr_i,
  input  logic                     poll_hit_i,
  input  logic [$clog2(LINES)-1:0] poll_line_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     poll_ack_o,
  output logic                     init_clear_o,
  output logic                     eoi_o,
  output logic                     eoi_rot_o,
  output logic                     eoi_spec_o,
  output logic                     rot_spec_o,
  output logic                     set_prio_o,
  output logic [$clog2(LINES)-1:0] cmd_line_o,
  output logic [DW-1:0]            vec_base_o,
  output logic                     auto_eoi_o,
  output logic                     nested_o,
  output logic                     special_mask_o,
  output logic                     rot_auto_eoi_o,
  output logic [DW-1:0]            mask_o
);
  localparam int LW = $clog2(LINES);

  logic    is_init, is_ctrl, is_cmd, is_data;
  op_e     op;
  logic [LW-1:0] line;

  irqc_word_decode #(.DW(DW), .LW(LW)) u_dec (
    .wr_i, .addr_i, .wdata_i,
    .is_init_o(is_init), .is_ctrl_o(is_ctrl), .is_cmd_o(is_cmd),
    .is_data_o(is_data), .op_o(op), .line_o(line)
  );

  irqc_init_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk_i, .rst_ni, .is_init_i(is_init), .is_data_i(is_data), .wdata_i,
    .mask_o, .vec_base_o, .nested_o, .auto_eoi_o
  );

  irqc_read_path #(.DW(DW), .LW(LW)) u_rd (
    .clk_i, .rst_ni, .rd_i, .addr_i,
    .clear_i(is_init),
    .arm_poll_i(is_ctrl && wdata_i[2]),
    .sel_we_i(is_ctrl && wdata_i[1]),
    .sel_val_i(wdata_i[0]),
    .req_i, .isr_i, .mask_i(mask_o), .poll_hit_i, .poll_line_i,
    .rdata_o, .poll_ack_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_clear_o   <= 1'b0;
      eoi_o          <= 1'b0;
      eoi_rot_o      <= 1'b0;
      eoi_spec_o     <= 1'b0;
      rot_spec_o     <= 1'b0;
      set_prio_o     <= 1'b0;
      cmd_line_o     <= '0;
      special_mask_o <= 1'b0;
      rot_auto_eoi_o <= 1'b0;
    end else begin
      init_clear_o <= is_init;
      eoi_o        <= is_cmd && op == OP_EOI;
      eoi_rot_o    <= is_cmd && op == OP_EOI_ROT;
      eoi_spec_o   <= is_cmd && op == OP_EOI_SPEC;
      rot_spec_o   <= is_cmd && op == OP_ROT_SPEC;
      set_prio_o   <= is_cmd && op == OP_SET_PRIO;
      if (is_cmd) cmd_line_o <= line;
      if (is_init) begin
        special_mask_o <= 1'b0;
        rot_auto_eoi_o <= 1'b0;
      end else begin
        if (is_ctrl && wdata_i[6]) special_mask_o <= wdata_i[5];
        if (is_cmd && op == OP_ROT_CLR) rot_auto_eoi_o <= 1'b0;
        if (is_cmd && op == OP_ROT_SET) rot_auto_eoi_o <= 1'b1;
      end
    end
  end

  a_r9_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({init_clear_o, eoi_o, eoi_rot_o, eoi_spec_o, rot_spec_o, set_prio_o}));
  a_r2_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=> (init_clear_o && !special_mask_o && !rot_auto_eoi_o));
  a_r9_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[7:3] == 5'b01000) |=>
      !(eoi_o || eoi_rot_o || eoi_spec_o || rot_spec_o || set_prio_o || init_clear_o));
  a_r7_smm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !addr_i) |=> $stable(special_mask_o) && $stable(rot_auto_eoi_o));
endmodule

// File: tb/tb_irqc_prog_port.sv
module tb_irqc_prog_port;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_i = 0, rd_i = 0, addr_i = 0;
  logic [7:0] wdata_i = 0, req_i = 0, isr_i = 0;
  logic poll_hit_i = 0;
  logic [2:0] poll_line_i = 0;
  logic [7:0] rdata_o, vec_base_o, mask_o;
  logic poll_ack_o, init_clear_o, eoi_o, eoi_rot_o, eoi_spec_o, rot_spec_o, set_prio_o;
  logic [2:0] cmd_line_o;
  logic auto_eoi_o, nested_o, special_mask_o, rot_auto_eoi_o;

  always #5 clk = ~clk;

  irqc_prog_port dut (.clk_i(clk), .*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // model
  int st = 0;
  bit need4 = 0, m_poll = 0, m_sel = 0, m_smm = 0, m_rot = 0, m_nest = 0, m_aeoi = 0;
  logic [7:0] m_mask = 0, m_vec = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg();
    chk("R6 mask", mask_o, m_mask);
    chk("R3 vector base", vec_base_o, m_vec);
    chk("R5 nested", nested_o, m_nest);
    chk("R5 auto-eoi", auto_eoi_o, m_aeoi);
    chk("R7 special mask", special_mask_o, m_smm);
    chk("R8 rotate flag", rot_auto_eoi_o, m_rot);
  endtask

  // expected strobes {init,eoi,eoi_rot,eoi_spec,rot_spec,set_prio}
  function automatic logic [5:0] exp_strobes(logic a, logic [7:0] d);
    if (a) return 6'b0;
    if (d[4]) return 6'b100000;
    if (d[3]) return 6'b0;
    case (d[7:5])
      3'd1: return 6'b010000;
      3'd5: return 6'b001000;
      3'd3: return 6'b000100;
      3'd7: return 6'b000010;
      3'd6: return 6'b000001;
      default: return 6'b0;
    endcase
  endfunction

  task automatic model_wr(logic a, logic [7:0] d);
    if (!a) begin
      if (d[4]) begin
        m_mask = 0; m_vec = 0; m_nest = 0; m_aeoi = 0; m_sel = 0; m_poll = 0;
        m_smm = 0; m_rot = 0; st = 1; need4 = d[0];
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_sel = d[0];
        if (d[6]) m_smm = d[5];
      end else if (d[7:5] == 3'd0) m_rot = 0;
      else if (d[7:5] == 3'd4) m_rot = 1;
    end else begin
      case (st)
        0: m_mask = d;
        1: begin m_vec = d & 8'hF8; st = 2; end
        2: st = need4 ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; st = 0; end
      endcase
    end
  endtask

  task automatic do_wr(logic a, logic [7:0] d);
    logic [5:0] es;
    @(negedge clk);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 0;
    es = exp_strobes(a, d);
    model_wr(a, d);
    chk(es[5] ? "R2 strobes" : "R9 strobes",
        {init_clear_o, eoi_o, eoi_rot_o, eoi_spec_o, rot_spec_o, set_prio_o}, es);
    if (es[2] || es[1] || es[0]) chk("R9 line", cmd_line_o, d[2:0]);
    chk_cfg();
  endtask

  task automatic do_rd(logic a, logic [7:0] rq, logic [7:0] is, logic hit, logic [2:0] ln);
    logic [7:0] er;
    logic ea;
    @(negedge clk);
    rd_i = 1; addr_i = a; req_i = rq; isr_i = is; poll_hit_i = hit; poll_line_i = ln;
    @(negedge clk);
    rd_i = 0;
    if (m_poll) begin
      er = hit ? {5'b0, ln} : 8'h07; ea = hit; m_poll = 0;
      chk("R11 poll data", rdata_o, er);
      chk("R11 poll ack", poll_ack_o, ea);
    end else begin
      er = a ? m_mask : (m_sel ? is : rq);
      chk("R10 read data", rdata_o, er);
      chk("R10 no ack", poll_ack_o, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {init_clear_o, eoi_o, eoi_rot_o, eoi_spec_o, rot_spec_o, set_prio_o, poll_ack_o}, 0);
    chk_cfg();
    do_rd(0, 8'h5A, 8'hA5, 1, 3);   // R1 select=request, poll off
    do_wr(1, 8'hC3);                // R1/R6 mask in run state
    // R2..R5 four-word sequence
    do_wr(0, 8'h11);
    do_wr(1, 8'h6F);                // R3 base -> 68
    do_wr(1, 8'hFF);                // R4 ignored
    do_wr(1, 8'h12);                // R5 nested + auto-eoi
    do_wr(1, 8'h3C);                // R6
    // three-word sequence, R4 path back to run
    do_wr(0, 8'h10);
    do_wr(1, 8'h27);
    do_wr(1, 8'h99);                // R4 ignored
    do_wr(1, 8'h81);                // R6 mask again
    // R7 control words
    do_wr(0, 8'h0B); do_rd(0, 8'h01, 8'h80, 0, 0);
    do_wr(0, 8'h69);                // smm=1, sel unchanged
    do_rd(0, 8'h01, 8'h40, 0, 0);
    do_wr(0, 8'h0A); do_rd(0, 8'h22, 8'h44, 0, 0);
    do_wr(0, 8'h48);                // smm cleared
    // R8, R9 all command codes
    for (int c = 0; c < 8; c++) do_wr(0, {c[2:0], 2'b00, 3'(7 - c)});
    // R11 poll hit and miss
    do_wr(0, 8'h0C); do_rd(1, 8'h00, 8'h00, 1, 5);
    do_rd(1, 8'h00, 8'h00, 1, 5);   // disarmed, reads mask
    do_wr(0, 8'h0C); do_rd(0, 8'hFF, 8'hFF, 0, 2);
    // R2 restart mid-sequence
    do_wr(0, 8'h11); do_wr(1, 8'h50); do_wr(0, 8'h10); do_wr(1, 8'hA8);
    do_wr(1, 8'h00); do_wr(1, 8'h0F);
    // random mix
    void'($urandom(32'h1234));
    for (int i = 0; i < 4000; i++) begin
      d = 8'($urandom);
      if ($urandom % 3 == 0)
        do_rd(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
      else
        do_wr(1'($urandom), d);
    end
    finish_run();
  end
endmodule